// File: doc/BRIEF.md
# Register File with Write-Through Bypass

A 32-entry, 32-bit general-purpose register file for an in-order pipeline. It has two combinational read ports and one write port. The decode stage reads source operands in the same cycle that the write-back stage writes a result. Without extra logic, a read of the register being written in that cycle would return the old value. This block routes the incoming write data straight to any read port whose address equals the enabled write address, so the reader gets the new value with no stall and no external forwarding path.

Register 0 is hard-wired to zero. Writes to it are discarded, and it is never bypassed. The write takes effect on the rising clock edge. An active-low asynchronous reset clears every entry.

Top module: `rf_bypass_top`

## Requirements
- R1: While `rst_ni` is low, and on every read after reset until a register is written, every register reads as zero on both ports.
- R2: Address 0 always reads as 32'h0 on both ports. A write to address 0 is discarded, and a read of address 0 never returns the write data, even when `wr_en_i` is high with `wr_addr_i` = 0.
- R3: When `wr_en_i` is high at a rising edge of `clk_i`, the entry `wr_addr_i` (if nonzero) takes `wr_data_i`. From the next cycle on, reads of that address return the new value until it is written again.
- R4: While `wr_en_i` is low, no entry changes, and each port returns the stored value even if its address equals `wr_addr_i`.
- R5: When `wr_en_i` is high and a read address equals a nonzero `wr_addr_i`, that port returns `wr_data_i` in the same cycle, before the edge that stores it.
- R6: Both read ports bypass at once when both addresses equal the enabled nonzero write address.
- R7: Read data is combinational in the read address: a change of address changes the read data with no clock edge.
- R8: A port whose address differs from the enabled write address returns the stored value while the other port is bypassing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes commit on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; clears all entries |
| rd_addr_a_i | input | 5 | Read port A register number |
| rd_data_a_o | output | 32 | Read port A data |
| rd_addr_b_i | input | 5 | Read port B register number |
| rd_data_b_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write register number |
| wr_data_i | input | 32 | Write data |

## Verification
Bypassed and zero reads are due in the same cycle as the stimulus. The bench therefore drives inputs just after the falling edge and samples both ports 1 ns later, before the next rising edge. A write becomes visible as stored data from the cycle after its rising edge. The bench's reference array updates only at that edge, so any later read compares against the committed value. The combinational-read check changes addresses several times inside one low clock phase and samples after each change, with no edge in between. The sweeps write every register, including register 0, and read every address pair. A random phase then forces frequent address matches across both ports.

// File: rtl/rf_bypass_pkg.sv
package rf_bypass_pkg;
  // Source selected by a read port
  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_STORE  = 2'd1,
    SRC_BYPASS = 2'd2
  } rd_src_e;
endpackage

// File: rtl/rf_wr_dec.sv
module rf_wr_dec #(
  parameter int NUM_REGS = 32,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic [NUM_REGS-1:0] wr_sel_o
);
  // Entry 0 is never selected
  assign wr_sel_o[0] = 1'b0;
  for (genvar i = 1; i < NUM_REGS; i++) begin : g_sel
    assign wr_sel_o[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] wr_sel_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   regs_o [NUM_REGS]
);
  assign regs_o[0] = '0;
  for (genvar i = 1; i < NUM_REGS; i++) begin : g_ent
    logic [DATA_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          ent_q <= '0;
      else if (wr_sel_i[i]) ent_q <= wr_data_i;
    end
    assign regs_o[i] = ent_q;
  end
  // wr_sel_i[0] is tied low by the decoder
  logic unused_sel0;
  assign unused_sel0 = wr_sel_i[0];
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port
  import rf_bypass_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] regs_i [NUM_REGS],
  output logic [DATA_W-1:0] rd_data_o
);
  rd_src_e src;

  always_comb begin
    if (rd_addr_i == '0)                           src = SRC_ZERO;
    else if (wr_en_i && (wr_addr_i == rd_addr_i))  src = SRC_BYPASS;
    else                                           src = SRC_STORE;
  end

  always_comb begin
    unique case (src)
      SRC_BYPASS: rd_data_o = wr_data_i;
      SRC_STORE:  rd_data_o = regs_i[rd_addr_i];
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/rf_bypass_top.sv
module rf_bypass_top #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W = $clog2(NUM_REGS),
  localparam int NUM_RD = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_a_i,
  output logic [DATA_W-1:0] rd_data_a_o,
  input  logic [ADDR_W-1:0] rd_addr_b_i,
  output logic [DATA_W-1:0] rd_data_b_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [NUM_REGS-1:0] wr_sel;
  logic [DATA_W-1:0]   regs [NUM_REGS];
  logic [ADDR_W-1:0]   rd_addr [NUM_RD];
  logic [DATA_W-1:0]   rd_data [NUM_RD];

  rf_wr_dec #(.NUM_REGS(NUM_REGS)) u_dec (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_sel_o (wr_sel)
  );

  rf_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_sel_i (wr_sel),
    .wr_data_i(wr_data_i),
    .regs_o   (regs)
  );

  assign rd_addr[0] = rd_addr_a_i;
  assign rd_addr[1] = rd_addr_b_i;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_rd_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_port (
      .rd_addr_i(rd_addr[p]),
      .wr_en_i  (wr_en_i),
      .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i),
      .regs_i   (regs),
      .rd_data_o(rd_data[p])
    );
  end

  assign rd_data_a_o = rd_data[0];
  assign rd_data_b_o = rd_data[1];
endmodule

// File: rtl/rf_bypass_chk.sv
module rf_bypass_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] rd_addr_a_i,
  input logic [DATA_W-1:0] rd_data_a_o,
  input logic [ADDR_W-1:0] rd_addr_b_i,
  input logic [DATA_W-1:0] rd_data_b_o,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i
);
  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (rd_data_a_o == '0 && rd_data_b_o == '0));

  a_r2_zero_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_a_i == '0 |-> rd_data_a_o == '0);

  a_r2_zero_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_b_i == '0 |-> rd_data_b_o == '0);

  a_r5_bypass_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0 && wr_addr_i == rd_addr_a_i) |-> rd_data_a_o == wr_data_i);

  a_r5_bypass_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0 && wr_addr_i == rd_addr_b_i) |-> rd_data_b_o == wr_data_i);

  // R3: committed value seen the cycle after the write
  a_r3_commit_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_en_i) && $past(wr_addr_i) != '0 &&
     rd_addr_a_i == $past(wr_addr_i) && !(wr_en_i && wr_addr_i == rd_addr_a_i))
    |-> rd_data_a_o == $past(wr_data_i));

  a_r4_hold_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(wr_en_i) && !wr_en_i && rd_addr_a_i == $past(rd_addr_a_i))
    |-> $stable(rd_data_a_o));

  a_r6_ports_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_a_i == rd_addr_b_i |-> rd_data_a_o == rd_data_b_o);
endmodule

bind rf_bypass_top rf_bypass_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_addr_a_i(rd_addr_a_i),
  .rd_data_a_o(rd_data_a_o),
  .rd_addr_b_i(rd_addr_b_i),
  .rd_data_b_o(rd_data_b_o),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i)
);

// File: tb/rf_bypass_top_tb_top.sv
`timescale 1ns/1ps
module rf_bypass_top_tb_top;
  localparam int NR = 32;
  localparam int DW = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ra = '0, rb = '0, wa = '0;
  logic          we = 1'b0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] qa, qb;

  logic [DW-1:0] mdl [NR];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rf_bypass_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_addr_a_i(ra), .rd_data_a_o(qa),
    .rd_addr_b_i(rb), .rd_data_b_o(qb),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd)
  );

  function automatic logic [DW-1:0] pat(int i, int k);
    return (32'hA5C3_0000 ^ (32'(i) * 32'h0101_0101)) + 32'(k * 977);
  endfunction

  function automatic logic [DW-1:0] expect_rd(logic [AW-1:0] a);
    if (a == '0) return '0;
    if (we && wa == a) return wd;
    return mdl[a];
  endfunction

  function automatic string tag_of(logic [AW-1:0] a, logic [AW-1:0] other);
    if (a == '0) return "R2";
    if (we && wa == a) return (a == other) ? "R6" : "R5";
    if (we) return "R8";
    return "R3";
  endfunction

  task automatic cmp(string tag, string port, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s port %s: actual %h expected %h", tag, port, act, exp);
    end
  endtask

  // Drive after falling edge, sample 1 ns later, model commits at rising edge
  task automatic step(logic [AW-1:0] a, logic [AW-1:0] b, logic e,
                      logic [AW-1:0] w, logic [DW-1:0] d, string lbl);
    @(negedge clk);
    ra = a; rb = b; we = e; wa = w; wd = d;
    #1;
    cmp((lbl != "") ? lbl : tag_of(a, b), "A", qa, expect_rd(a));
    cmp((lbl != "") ? lbl : tag_of(b, a), "B", qb, expect_rd(b));
    @(posedge clk);
    if (we && wa != '0) mdl[wa] = wd;
  endtask

  initial begin
    for (int i = 0; i < NR; i++) mdl[i] = '0;
    // R1: reads during reset
    #1;
    for (int i = 0; i < NR; i += 7) begin
      ra = AW'(i); rb = AW'(NR - 1 - i); #0.5;
      cmp("R1", "A", qa, '0);
      cmp("R1", "B", qb, '0);
    end
    #10;
    @(negedge clk); rst_n = 1'b1;

    // R1: all zero after reset
    for (int i = 0; i < NR; i++) step(AW'(i), AW'((i + 5) % NR), 1'b0, '0, '0, "R1");

    // R5 / R2: write every register while port A reads it, B reads the next
    for (int i = 0; i < NR; i++) step(AW'(i), AW'((i + 1) % NR), 1'b1, AW'(i), pat(i, 1), "");

    // R2: writes to register 0 discarded and not bypassed
    step('0, '0, 1'b1, '0, 32'hDEAD_BEEF, "R2");
    step('0, '0, 1'b0, '0, '0, "R2");

    // R3: full pair sweep of stored values
    for (int a = 0; a < NR; a++)
      for (int b = 0; b < NR; b++) step(AW'(a), AW'(b), 1'b0, '0, '0, "");

    // R4: disabled write with matching address returns stored value
    for (int i = 1; i < NR; i += 3) step(AW'(i), AW'(i), 1'b0, AW'(i), ~pat(i, 1), "R4");
    for (int i = 1; i < NR; i += 3) step(AW'(i), AW'(i), 1'b0, '0, '0, "R4");

    // R6: both ports bypass at once
    for (int i = 1; i < NR; i++) step(AW'(i), AW'(i), 1'b1, AW'(i), pat(i, 2), "");
    // R8: port B bypasses while A reads a stored entry
    for (int i = 1; i < NR; i++) step(AW'(NR - i), AW'(i), 1'b1, AW'(i), pat(i, 3), "");

    // R7: combinational address change, no clock edge in between
    @(negedge clk);
    we = 1'b0;
    for (int i = 0; i < 5; i++) begin
      ra = AW'(3 * i + 1); rb = AW'(31 - 2 * i); #0.4;
      cmp("R7", "A", qa, mdl[3 * i + 1]);
      cmp("R7", "B", qb, mdl[31 - 2 * i]);
    end

    // Random traffic with biased address matches
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] w, a, b;
      logic e;
      w = AW'($urandom_range(0, NR - 1));
      e = ($urandom_range(0, 3) != 0);
      a = ($urandom_range(0, 2) == 0) ? w : AW'($urandom_range(0, NR - 1));
      b = ($urandom_range(0, 2) == 0) ? w : AW'($urandom_range(0, NR - 1));
      step(a, b, e, w, $urandom, "");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule